// File: doc/BRIEF.md
# Multichannel Phase-Delayed Square-Wave Generator

This block produces a bank of square waves that share one frequency. It has one reference line and a parameterised number of independent lines, 64 by default. The reference line always has zero phase. Each independent line lags the reference by its own 8-bit phase word. One full period is 512 timebase ticks, split into 256 ticks high and 256 ticks low. A phase word of P moves both edges of that line P ticks later than the reference edges, so the delay covers half a period (0 to 180 degrees).

The timebase is the 40 MHz input clock divided by 2^sel, where sel is a 3-bit select (1, 2, 4 and so on up to 128). This gives square-wave frequencies from 78.125 kHz down to about 0.61 kHz. Software fills two phase banks, a normal bank and an overdrive bank. A falling edge on the strobe input copies both banks, and the clock select, into held registers. The same edge restarts the period. Register writes made between strobes therefore never disturb the waveform. When overdrive is armed, the held overdrive phases play for a programmed number of whole periods, and then the held normal phases take over.

Each line has its own enable. A disabled line drives low and raises its high-impedance indication. While the scan input is low, every line, including the reference, is parked in the same way.

Top module: `sqw_array_gen`

## Requirements
- R1: While scanning, the reference output is high when the tick position within the period is 0 to 255 and low when it is 256 to 511. The tick position is 0 on the first clock after a strobe falling edge.
- R2: While scanning and enabled, channel i is high exactly when (position - P_i) mod 512 < 256, where P_i is its active 8-bit phase. Channel i's phase word sits at bits [8i+7:8i] of the flat phase inputs.
- R3: The position advances by one every 2^sel clocks, where sel is the held 3-bit clock select (0 means every clock, 7 means every 128 clocks).
- R4: A strobe falling edge (high in one clock, low in the next) resets the position and copies both phase banks into the held registers. Changing the phase inputs without a falling edge has no effect on the outputs.
- R5: If overdrive is enabled and the 4-bit cycle count N is nonzero at the falling edge, the held overdrive phases drive the channels for N complete periods. The held normal phases drive them from then on.
- R6: If overdrive is disabled, or N is zero, at the falling edge, the held normal phases apply from the first period.
- R7: A channel whose enable bit is 0 drives low and asserts its high-impedance indication. An enabled channel's indication is low while scanning.
- R8: While the scan input is low, all channel outputs and the reference output are low, and all high-impedance indications are high.
- R9: A change of the clock select takes effect only at the next strobe falling edge.
- R10: After reset the position starts at 0, the held phases are zero, the held select is 0 and overdrive is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Scan state; low parks all outputs |
| sync_strobe | input | 1 | Update strobe; acts on its falling edge |
| clk_sel | input | 3 | Timebase divide exponent, held at the strobe |
| od_en | input | 1 | Overdrive arm |
| od_cycles | input | 4 | Number of overdrive periods |
| ch_en | input | 64 | Per-channel enable |
| norm_phase | input | 512 | Normal phase bank, 8 bits per channel |
| od_phase | input | 512 | Overdrive phase bank, 8 bits per channel |
| ch_out | output | 64 | Channel square waves |
| ch_hiz | output | 64 | Per-channel high-impedance indication |
| com_out | output | 1 | Reference square wave |
| com_hiz | output | 1 | Reference high-impedance indication |

## Verification
The assertions assume that every input is synchronous to the base clock and that a strobe falling edge is seen as high in one sampled clock and low in the next. The overdrive checks also assume that the cycle count and arm are only read at that edge. The stimulus changes inputs a short time after each rising edge. It holds the strobe high for exactly one clock per update, and it changes the bank contents, the select and the overdrive fields only between strobes. A behavioural model built from integers tracks the position, the held select and the overdrive countdown, and it is compared with all outputs on every falling clock edge.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
   typedef enum logic {
      BANK_NORM = 1'b0,
      BANK_OD   = 1'b1
   } bank_sel_e;
endpackage

// File: rtl/sqw_timebase.sv
module sqw_timebase #(
   parameter int SELW = 3,
   parameter int PERW = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic [SELW-1:0] sel_in,
   output logic            tick,
   output logic            wrap,
   output logic [PERW-1:0] pos
);
   localparam int PREW = (1 << SELW) - 1;

   logic [SELW-1:0] sel_q;
   logic [PREW-1:0] pre_q;
   logic [PREW:0]   mask_w;
   logic [PREW-1:0] mask;

   assign mask_w = ((PREW+1)'(1) << sel_q) - 1'b1;
   assign mask   = mask_w[PREW-1:0];
   assign tick   = (pre_q == mask);
   assign wrap   = tick && (&pos);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         pre_q <= '0;
         pos   <= '0;
      end else if (restart) begin
         sel_q <= sel_in;
         pre_q <= '0;
         pos   <= '0;
      end else if (tick) begin
         pre_q <= '0;
         pos   <= pos + 1'b1;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q <= mask) else $error("prescaler past divide limit"); // R3
   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pos == '0)) else $error("period not restarted"); // R4
   AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> $stable(sel_q)) else $error("select changed without strobe"); // R9
endmodule

// File: rtl/sqw_phase_bank.sv
module sqw_phase_bank
   import sqw_pkg::*;
#(
   parameter int NCH        = 64,
   parameter int PW         = 8,
   parameter int ODW        = 4,
   parameter bit OD_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              wrap,
   input  logic              od_en,
   input  logic [ODW-1:0]    od_cycles,
   input  logic [NCH*PW-1:0] norm_flat,
   input  logic [NCH*PW-1:0] od_flat,
   output logic [NCH*PW-1:0] act_flat
);
   logic [NCH*PW-1:0] norm_q;
   logic [NCH*PW-1:0] od_q;
   bank_sel_e         bank_q;
   logic [ODW-1:0]    left_q;
   logic              od_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    norm_q <= '0;
      else if (load) norm_q <= norm_flat;
   end

   generate
      if (OD_SUPPORT) begin : g_od
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               od_q   <= '0;
               bank_q <= BANK_NORM;
               left_q <= '0;
            end else if (load) begin
               od_q <= od_flat;
               if (od_en && (od_cycles != '0)) begin
                  bank_q <= BANK_OD;
                  left_q <= od_cycles;
               end else begin
                  bank_q <= BANK_NORM;
                  left_q <= '0;
               end
            end else if (wrap && (bank_q == BANK_OD)) begin
               left_q <= left_q - 1'b1;
               if (left_q == ODW'(1)) bank_q <= BANK_NORM;
            end
         end
      end else begin : g_no_od
         assign od_q   = '0;
         assign bank_q = BANK_NORM;
         assign left_q = '0;
      end
   endgenerate

   assign od_active = (bank_q == BANK_OD);
   assign act_flat  = od_active ? od_q : norm_q;

   AST_OD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(od_active) |-> ($past(wrap) || $past(load))) else $error("overdrive left mid-period"); // R5
   AST_OD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      od_active |-> (left_q != '0)) else $error("overdrive with empty count"); // R5
   AST_OD_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !(od_en && (od_cycles != '0))) |=> !od_active) else $error("overdrive not skipped"); // R6
endmodule

// File: rtl/sqw_chan.sv
module sqw_chan #(
   parameter int PW = 8
) (
   input  logic        [PW:0]   pos,
   input  logic        [PW-1:0] phase,
   input  logic                 drive_en,
   output logic                 wave,
   output logic                 hiz
);
   logic [PW:0] lag;

   assign lag  = pos - {1'b0, phase};
   assign wave = drive_en & ~lag[PW];
   assign hiz  = ~drive_en;
endmodule

// File: rtl/sqw_array_gen.sv
module sqw_array_gen #(
   parameter int NCH        = 64,
   parameter int PW         = 8,
   parameter int SELW       = 3,
   parameter int ODW        = 4,
   parameter bit OD_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan_en,
   input  logic              sync_strobe,
   input  logic [SELW-1:0]   clk_sel,
   input  logic              od_en,
   input  logic [ODW-1:0]    od_cycles,
   input  logic [NCH-1:0]    ch_en,
   input  logic [NCH*PW-1:0] norm_phase,
   input  logic [NCH*PW-1:0] od_phase,
   output logic [NCH-1:0]    ch_out,
   output logic [NCH-1:0]    ch_hiz,
   output logic              com_out,
   output logic              com_hiz
);
   localparam int PERW = PW + 1;

   if (NCH < 1)                begin : g_bad_nch  $error("NCH must be at least 1");      end
   if (PW < 1)                 begin : g_bad_pw   $error("PW must be at least 1");       end
   if (SELW < 1 || SELW > 4)   begin : g_bad_sel  $error("SELW must lie in 1..4");       end
   if (ODW < 1)                begin : g_bad_odw  $error("ODW must be at least 1");      end

   logic              sync_q;
   logic              sync_fall;
   logic              tick;
   logic              wrap;
   logic [PERW-1:0]   pos;
   logic [NCH*PW-1:0] act_flat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 1'b0;
      else        sync_q <= sync_strobe;
   end
   assign sync_fall = sync_q & ~sync_strobe;

   sqw_timebase #(.SELW(SELW), .PERW(PERW)) u_timebase (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (sync_fall),
      .sel_in  (clk_sel),
      .tick    (tick),
      .wrap    (wrap),
      .pos     (pos)
   );

   sqw_phase_bank #(.NCH(NCH), .PW(PW), .ODW(ODW), .OD_SUPPORT(OD_SUPPORT)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sync_fall),
      .wrap      (wrap),
      .od_en     (od_en),
      .od_cycles (od_cycles),
      .norm_flat (norm_phase),
      .od_flat   (od_phase),
      .act_flat  (act_flat)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      sqw_chan #(.PW(PW)) u_chan (
         .pos      (pos),
         .phase    (act_flat[i*PW +: PW]),
         .drive_en (scan_en & ch_en[i]),
         .wave     (ch_out[i]),
         .hiz      (ch_hiz[i])
      );
   end

   assign com_out = scan_en & ~pos[PW];
   assign com_hiz = ~scan_en;

   logic unused_tick;
   assign unused_tick = tick;

   AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_hiz & ch_out) == '0) else $error("parked channel driving high"); // R7
   AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en |-> ((&ch_hiz) && com_hiz && !com_out)) else $error("outputs live outside scan"); // R8
   AST_COM_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_fall && scan_en) |=> (com_out || !scan_en)) else $error("reference not high after strobe"); // R1
endmodule

// File: tb/sqw_array_gen_tb.sv
module sqw_array_gen_tb;
   localparam int NCH = 64;
   localparam int PW  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              scan_en = 1'b0;
   logic              sync_strobe = 1'b0;
   logic [2:0]        clk_sel = 3'd0;
   logic              od_en = 1'b0;
   logic [3:0]        od_cycles = 4'd0;
   logic [NCH-1:0]    ch_en = '1;
   logic [NCH*PW-1:0] norm_phase = '0;
   logic [NCH*PW-1:0] od_phase = '0;
   logic [NCH-1:0]    ch_out, ch_hiz;
   logic              com_out, com_hiz;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   bit compare_on = 1'b0;
   string cur_req = "R10";

   // behavioural model state
   int  m_pos, m_pre, m_sel, m_left;
   bit  m_od, m_sync_q;
   int  m_norm[NCH];
   int  m_odp[NCH];

   always #5 clk = ~clk;

   sqw_array_gen u_dut (
      .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .sync_strobe(sync_strobe),
      .clk_sel(clk_sel), .od_en(od_en), .od_cycles(od_cycles), .ch_en(ch_en),
      .norm_phase(norm_phase), .od_phase(od_phase),
      .ch_out(ch_out), .ch_hiz(ch_hiz), .com_out(com_out), .com_hiz(com_hiz)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pos = 0; m_pre = 0; m_sel = 0; m_left = 0; m_od = 0; m_sync_q = 0;
         for (int i = 0; i < NCH; i++) begin m_norm[i] = 0; m_odp[i] = 0; end
      end else begin
         if (m_sync_q && !sync_strobe) begin
            m_pos = 0; m_pre = 0; m_sel = clk_sel;
            for (int i = 0; i < NCH; i++) begin
               m_norm[i] = norm_phase[i*PW +: PW];
               m_odp[i]  = od_phase[i*PW +: PW];
            end
            if (od_en && od_cycles != 0) begin m_od = 1; m_left = od_cycles; end
            else begin m_od = 0; m_left = 0; end
         end else if (m_pre == (1 << m_sel) - 1) begin
            m_pre = 0;
            if (m_pos == 511) begin
               m_pos = 0;
               if (m_od) begin
                  m_left--;
                  if (m_left == 0) m_od = 0;
               end
            end else m_pos++;
         end else m_pre++;
         m_sync_q = sync_strobe;
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (compare_on) begin
         logic [NCH-1:0] e_out, e_hiz;
         logic e_com, e_chiz;
         for (int i = 0; i < NCH; i++) begin
            int p;
            bit en;
            p  = m_od ? m_odp[i] : m_norm[i];
            en = scan_en && ch_en[i];
            e_out[i] = en && (((m_pos - p + 512) % 512) < 256);
            e_hiz[i] = !en;
         end
         e_com  = scan_en && (m_pos < 256);
         e_chiz = !scan_en;
         tests++;
         if (ch_out !== e_out || ch_hiz !== e_hiz) begin
            fails++;
            $display("FAIL %s cycle %0d: ch_out=%h exp %h ch_hiz=%h exp %h",
                     cur_req, cycles, ch_out, e_out, ch_hiz, e_hiz);
         end
         tests++;
         if (com_out !== e_com || com_hiz !== e_chiz) begin
            fails++;
            $display("FAIL R1 cycle %0d: com_out=%b exp %b com_hiz=%b exp %b",
                     cycles, com_out, e_com, com_hiz, e_chiz);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic strobe();
      sync_strobe = 1'b1;
      step(1);
      sync_strobe = 1'b0;
      step(1);
   endtask

   task automatic set_norm(input int i, input int v);
      norm_phase[i*PW +: PW] = PW'(v);
   endtask

   task automatic set_od(input int i, input int v);
      od_phase[i*PW +: PW] = PW'(v);
   endtask

   initial begin
      step(3);
      compare_on = 1'b1;
      step(2);
      rst_n = 1'b1;
      // R10 / R8: idle after reset, then scan with zero held phases
      cur_req = "R8";  step(20);
      cur_req = "R10"; scan_en = 1'b1; step(600);

      // R2: spread phases, check across a full period
      cur_req = "R2";
      for (int i = 0; i < NCH; i++) set_norm(i, (i * 4 + (i % 3)) % 256);
      set_norm(0, 0); set_norm(1, 255); set_norm(2, 128); set_norm(3, 1);
      strobe(); step(1100);

      // R4: bank rewritten without a strobe, then applied
      cur_req = "R4";
      for (int i = 0; i < NCH; i++) set_norm(i, 255 - i);
      step(300);
      strobe(); step(600);

      // R9: select changed without strobe
      cur_req = "R9"; clk_sel = 3'd2; step(300);
      // R3: divide by 4, then by 2, then by 128 (partial period)
      cur_req = "R3"; strobe(); step(2100);
      clk_sel = 3'd1; strobe(); step(1100);
      clk_sel = 3'd7; strobe(); step(3000);
      clk_sel = 3'd0; strobe(); step(100);

      // R5: overdrive for two periods, then normal
      cur_req = "R5";
      for (int i = 0; i < NCH; i++) set_od(i, (i * 7 + 50) % 256);
      od_en = 1'b1; od_cycles = 4'd2;
      strobe(); step(1700);
      // strobe arriving during overdrive
      od_cycles = 4'd3; strobe(); step(700);
      strobe(); step(2000);

      // R6: count zero, then overdrive disarmed
      cur_req = "R6";
      od_cycles = 4'd0; strobe(); step(600);
      od_en = 1'b0; od_cycles = 4'd3; strobe(); step(600);

      // R7: per-channel disables
      cur_req = "R7";
      ch_en = 64'h5A5A_0F0F_FFFF_0001; step(600);
      ch_en = '0; step(50);
      ch_en = '1; step(50);

      // R8: leave scan, then return
      cur_req = "R8"; scan_en = 1'b0; step(100);
      cur_req = "R2"; scan_en = 1'b1; step(100);

      compare_on = 1'b0;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      fails++;
      tests++;
      $display("FAIL watchdog: cycles=%0d exp below 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule